// File: doc/BRIEF.md
# Two-Wire Target Control Register Bank

This block is an I2C-bus target that holds eight 8-bit control registers for downstream logic. An external master writes a register pointer and then any number of data bytes, or sets the pointer and reads bytes back after a repeated START. All eight register values are always visible on one flat parallel output bus.

SCL and SDA arrive asynchronously. They pass through a synchronizer and an edge detector that run on a system clock at least eight times the SCL rate. The block never drives SDA high. It asserts a single drive-low output, which an open-drain pad or a wired-AND bus model turns into the SDA line. Two strap inputs supply the low bits of the device address, so four of these targets can share one bus.

Top module: `twi_regfile`

## Requirements
- R1: After reset all eight registers read zero, the pointer is 0 and `sda_drive_low` is 0.
- R2: A falling SDA while SCL is high is a START and begins a new address phase from any state. A rising SDA while SCL is high is a STOP and returns the block to idle with SDA released. Neither is taken as a data bit.
- R3: The block responds to the 7-bit address whose upper five bits are 10110 and whose two low bits equal `addr_sel[1:0]`. That byte is sent MSB first, followed by the R/W bit (0 = write, 1 = read), and the block acknowledges it on the ninth SCL pulse.
- R4: An address that does not match gets no acknowledge. Every byte after it is ignored, including a copy of the block's own address, until the next START.
- R5: `sda_drive_low` changes only while SCL is low. An acknowledge holds SDA low for the whole high phase of the ninth pulse.
- R6: In a write, the first byte after the address loads the pointer from its three low bits. The upper five bits are ignored.
- R7: Each further write byte is stored in the pointed register, is acknowledged, and advances the pointer by one. Register k appears on `regs_out[8k+7:8k]`.
- R8: The pointer wraps modulo 8. A ninth data byte in one write overwrites register 0, then register 1, and so on.
- R9: A data byte cut short by a STOP or a repeated START changes no register and does not advance the pointer.
- R10: After an address with R/W=1 is acknowledged, the pointed register is shifted out MSB first. Each master acknowledge advances the pointer modulo 8 and starts the next register.
- R11: On a master NACK the block releases SDA and keeps it released until the next START. The pointer keeps the address of the byte just read, so a following read without a pointer byte returns the same register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as seen at the pad |
| sda_in | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 2 | Strap value for the two low address bits |
| sda_drive_low | output | 1 | 1 pulls SDA low; 0 releases it |
| regs_out | output | 64 | All eight registers, register k in bits [8k+7:8k] |

## Verification
The bench targets these corner cases:
- A write of ten bytes starting at pointer 6. A pointer without modulo-8 wrapping would write past the bank, leaving registers 6 and 7 with stale first-pass data.
- Data bytes aborted after a few bits by a STOP or by a repeated START. An engine that commits on a bit count alone would store a half-shifted value, or advance the pointer, which the current-address read that follows exposes.
- A mismatched address followed by the block's own address sent without a START. This shows whether the block really stays deaf until the next START.
- A read across register 7 into register 0.
- A master NACK followed by more clocking. A design that kept driving would corrupt the line or advance the pointer.

// File: rtl/twi_regfile_pkg.sv
package twi_regfile_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_RX, ST_ACK, ST_TX, ST_MACK} twi_state_e;
  typedef enum logic [1:0] {RX_ADDR, RX_PTR, RX_DATA} rx_kind_e;
endpackage

// File: rtl/twi_line_sync.sv
module twi_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [STAGES-1:0] scl_pipe, sda_pipe;
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= {scl_pipe[STAGES-2:0], scl_in};
      sda_pipe <= {sda_pipe[STAGES-2:0], sda_in};
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  // SDA moving while SCL is steadily high is a bus condition, never data
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/twi_target_fsm.sv
module twi_target_fsm
  import twi_regfile_pkg::*;
#(
  parameter int         DW        = 8,
  parameter int         PW        = 3,
  parameter int         SELW      = 2,
  parameter logic [6:0] BASE_ADDR = 7'b1011000
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            scl_s,
  input  logic            sda_s,
  input  logic            scl_rise,
  input  logic            scl_fall,
  input  logic            start_det,
  input  logic            stop_det,
  input  logic [SELW-1:0] addr_sel,
  input  logic [DW-1:0]   rd_data,
  output logic [PW-1:0]   rd_addr,
  output logic            wr_en,
  output logic [PW-1:0]   wr_addr,
  output logic [DW-1:0]   wr_data,
  output logic            sda_drive_low
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] CNT_FULL = CW'(DW);
  localparam logic [CW-1:0] CNT_LAST = CW'(DW - 1);

  twi_state_e    state;
  rx_kind_e      kind;
  logic [CW-1:0] cnt;
  logic [DW-1:0] shreg;
  logic [PW-1:0] ptr;
  logic          rw, mack;
  logic [6:0]    dev_addr;

  assign dev_addr = {BASE_ADDR[6:SELW], addr_sel};
  assign rd_addr  = (state == ST_MACK) ? ptr + 1'b1 : ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      kind          <= RX_ADDR;
      cnt           <= '0;
      shreg         <= '0;
      ptr           <= '0;
      rw            <= 1'b0;
      mack          <= 1'b0;
      wr_en         <= 1'b0;
      wr_addr       <= '0;
      wr_data       <= '0;
      sda_drive_low <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      if (stop_det) begin
        state         <= ST_IDLE;
        sda_drive_low <= 1'b0;
      end else if (start_det) begin
        state         <= ST_RX;
        kind          <= RX_ADDR;
        cnt           <= '0;
        sda_drive_low <= 1'b0;
      end else begin
        case (state)
          ST_RX: begin
            if (scl_rise) begin
              shreg <= {shreg[DW-2:0], sda_s};
              cnt   <= cnt + 1'b1;
            end else if (scl_fall && cnt == CNT_FULL) begin
              // full byte received: act on it and drive the acknowledge
              case (kind)
                RX_ADDR: begin
                  if (shreg[DW-1:1] == dev_addr) begin
                    rw            <= shreg[0];
                    sda_drive_low <= 1'b1;
                    state         <= ST_ACK;
                  end else begin
                    state <= ST_IDLE;
                  end
                end
                RX_PTR: begin
                  ptr           <= shreg[PW-1:0];
                  sda_drive_low <= 1'b1;
                  state         <= ST_ACK;
                end
                default: begin
                  wr_en         <= 1'b1;
                  wr_addr       <= ptr;
                  wr_data       <= shreg;
                  ptr           <= ptr + 1'b1;
                  sda_drive_low <= 1'b1;
                  state         <= ST_ACK;
                end
              endcase
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              cnt <= '0;
              if (kind == RX_ADDR && rw) begin
                shreg         <= rd_data;
                sda_drive_low <= ~rd_data[DW-1];
                state         <= ST_TX;
              end else begin
                sda_drive_low <= 1'b0;
                state         <= ST_RX;
                kind          <= (kind == RX_ADDR) ? RX_PTR : RX_DATA;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (cnt == CNT_LAST) begin
                sda_drive_low <= 1'b0;
                state         <= ST_MACK;
              end else begin
                shreg         <= {shreg[DW-2:0], 1'b0};
                sda_drive_low <= ~shreg[DW-2];
                cnt           <= cnt + 1'b1;
              end
            end
          end
          ST_MACK: begin
            if (scl_rise) begin
              mack <= ~sda_s;
            end else if (scl_fall) begin
              if (mack) begin
                ptr           <= ptr + 1'b1;
                shreg         <= rd_data;
                sda_drive_low <= ~rd_data[DW-1];
                cnt           <= '0;
                state         <= ST_TX;
              end else begin
                state <= ST_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R5: the drive only moves during SCL low, apart from a bus condition release
  assert_drv_scl_low_R5: assert property (@(posedge clk) disable iff (rst)
    (sda_drive_low != $past(sda_drive_low)) |->
      (!$past(scl_s) || $past(start_det) || $past(stop_det)));

  assert_stop_idle_R2: assert property (@(posedge clk) disable iff (rst)
    stop_det |=> (state == ST_IDLE && !sda_drive_low));

  assert_start_addr_R2: assert property (@(posedge clk) disable iff (rst)
    (start_det && !stop_det) |=> (state == ST_RX && kind == RX_ADDR && cnt == '0));

  assert_idle_released_R11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> !sda_drive_low);

  assert_commit_clean_R9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (!$past(start_det) && !$past(stop_det)));
endmodule

// File: rtl/twi_reg_bank.sv
module twi_reg_bank #(
  parameter int NREG = 8,
  parameter int DW   = 8,
  parameter int PW   = $clog2(NREG)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [PW-1:0]      waddr,
  input  logic [DW-1:0]      wdata,
  input  logic [PW-1:0]      raddr,
  output logic [DW-1:0]      rdata,
  output logic [NREG*DW-1:0] regs_flat
);
  logic [DW-1:0] mem [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NREG; k++) mem[k] <= '0;
    end else if (we) begin
      mem[waddr] <= wdata;
    end
  end

  assign rdata = mem[raddr];

  for (genvar g = 0; g < NREG; g++) begin : g_flat
    assign regs_flat[g*DW +: DW] = mem[g];
  end

  assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
    we |=> (mem[$past(waddr)] == $past(wdata)));
endmodule

// File: rtl/twi_regfile.sv
module twi_regfile #(
  parameter int         NREG        = 8,
  parameter int         DW          = 8,
  parameter int         SELW        = 2,
  parameter logic [6:0] BASE_ADDR   = 7'b1011000,
  parameter int         SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               scl_in,
  input  logic               sda_in,
  input  logic [SELW-1:0]    addr_sel,
  output logic               sda_drive_low,
  output logic [NREG*DW-1:0] regs_out
);
  localparam int PW = $clog2(NREG);

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic wr_en;
  logic [PW-1:0] wr_addr, rd_addr;
  logic [DW-1:0] wr_data, rd_data;

  twi_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_in(scl_in), .sda_in(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  twi_target_fsm #(.DW(DW), .PW(PW), .SELW(SELW), .BASE_ADDR(BASE_ADDR)) u_fsm (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det), .addr_sel(addr_sel),
    .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .sda_drive_low(sda_drive_low)
  );

  twi_reg_bank #(.NREG(NREG), .DW(DW), .PW(PW)) u_bank (
    .clk(clk), .rst(rst), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data), .regs_flat(regs_out)
  );
endmodule

// File: tb/twi_regfile_tb.sv
module twi_regfile_tb;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        scl = 1'b1;
  logic        sda_m = 1'b1;
  logic [1:0]  addr_sel = 2'b01;
  logic        sda_drive_low;
  logic [63:0] regs_out;
  logic        sda_line;

  assign sda_line = sda_m & ~sda_drive_low;

  twi_regfile u_dut (
    .clk(clk), .rst(rst), .scl_in(scl), .sda_in(sda_line),
    .addr_sel(addr_sel), .sda_drive_low(sda_drive_low), .regs_out(regs_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0;
  int n_bad = 0;
  int r5_viol = 0;
  bit done = 0;
  logic [7:0] exp_regs [8];
  logic [2:0] exp_ptr;

  // R5 monitor at the pins: the drive must not move while SCL stays high
  logic prev_drv = 1'b0, prev_scl = 1'b1;
  always @(negedge clk) begin
    if (!rst && scl && prev_scl && (sda_drive_low !== prev_drv)) r5_viol++;
    prev_drv = sda_drive_low;
    prev_scl = scl;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  function automatic logic [63:0] flat_exp();
    logic [63:0] f;
    for (int k = 0; k < 8; k++) f[k*8 +: 8] = exp_regs[k];
    return f;
  endfunction

  function automatic logic [7:0] addr_byte(input logic [1:0] sel, input bit rd);
    return {5'b10110, sel, rd};
  endfunction

  task automatic wait_q();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wait_q();
    scl = 1'b1;   wait_q();
    sda_m = 1'b0; wait_q();
    scl = 1'b0;   wait_q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wait_q();
    scl = 1'b1;   wait_q();
    sda_m = 1'b1; wait_q();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 0; i < n; i++) begin
      sda_m = b[7-i]; wait_q();
      scl = 1'b1; wait_q(); wait_q();
      scl = 1'b0; wait_q();
    end
  endtask

  // ninth pulse: line must be low both just after the rise and just before the fall
  task automatic get_ack(output bit ack);
    logic a1, a2;
    sda_m = 1'b1; wait_q();
    scl = 1'b1;
    @(negedge clk); a1 = sda_line;
    repeat (2*Q - 2) @(negedge clk);
    a2 = sda_line;
    @(negedge clk); scl = 1'b0; wait_q();
    ack = !a1 && !a2;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    get_ack(ack);
  endtask

  task automatic read_byte(input bit master_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 0; i < 8; i++) begin
      wait_q(); scl = 1'b1; wait_q();
      b = {b[6:0], sda_line};
      wait_q(); scl = 1'b0; wait_q();
    end
    sda_m = ~master_ack; wait_q();
    scl = 1'b1; wait_q(); wait_q();
    scl = 1'b0; wait_q();
    sda_m = 1'b1;
  endtask

  task automatic do_write(input logic [7:0] p, input int n);
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte(addr_byte(addr_sel, 1'b0), ack); chk(ack, "R3 address ack", 64'(ack), 1);
    send_byte(p, ack);                         chk(ack, "R6 pointer ack", 64'(ack), 1);
    exp_ptr = p[2:0];
    for (int i = 0; i < n; i++) begin
      d = 8'($urandom);
      send_byte(d, ack); chk(ack, "R7 data ack", 64'(ack), 1);
      exp_regs[exp_ptr] = d;
      exp_ptr = exp_ptr + 3'd1;
    end
    bus_stop();
    chk(regs_out == flat_exp(), "R7/R8 regs_out after write", regs_out, flat_exp());
    chk(!sda_drive_low, "R2 released after STOP", 64'(sda_drive_low), 0);
  endtask

  // optional pointer byte; then repeated START and read n bytes, NACK on the last
  task automatic do_read(input bit set_ptr, input logic [7:0] p, input int n);
    bit ack;
    logic [7:0] b;
    bus_start();
    if (set_ptr) begin
      send_byte(addr_byte(addr_sel, 1'b0), ack); chk(ack, "R3 address ack", 64'(ack), 1);
      send_byte(p, ack);                         chk(ack, "R6 pointer ack", 64'(ack), 1);
      exp_ptr = p[2:0];
      bus_start();
    end
    send_byte(addr_byte(addr_sel, 1'b1), ack); chk(ack, "R10 read address ack", 64'(ack), 1);
    for (int i = 0; i < n; i++) begin
      read_byte(i < n - 1, b);
      chk(b == exp_regs[exp_ptr], "R10 read data", 64'(b), 64'(exp_regs[exp_ptr]));
      if (i < n - 1) exp_ptr = exp_ptr + 3'd1;
    end
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic [7:0] b;
    void'($urandom(32'h5EED));
    for (int k = 0; k < 8; k++) exp_regs[k] = 8'h00;
    exp_ptr = 3'd0;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk(regs_out == 64'h0, "R1 regs after reset", regs_out, 0);
    chk(!sda_drive_low, "R1 drive after reset", 64'(sda_drive_low), 0);
    do_read(1'b0, 8'h00, 1);  // R1 pointer 0: current-address read gives reg 0

    // R7 basic write, R6 pointer upper bits ignored
    do_write(8'h02, 3);
    do_write(8'hFB, 2);

    // R8 wrap across the end of the bank
    do_write(8'h06, 10);

    // R10 read across register 7 into register 0
    do_read(1'b1, 8'h07, 3);

    // R11 NACK: line stays released under further clocking, pointer held
    do_read(1'b1, 8'h04, 1);
    bus_start();
    send_byte(addr_byte(addr_sel, 1'b1), ack);
    read_byte(1'b0, b);
    chk(b == exp_regs[4], "R11 read before NACK", 64'(b), 64'(exp_regs[4]));
    send_bits(8'hFF, 8);
    get_ack(ack);
    chk(!ack, "R11 line released after NACK", 64'(ack), 0);
    bus_stop();
    do_read(1'b0, 8'h00, 1);  // R11 current read still at register 4

    // R4 mismatched low bits, then own address without a START
    bus_start();
    send_byte({5'b10110, ~addr_sel, 1'b0}, ack); chk(!ack, "R4 low bits mismatch", 64'(ack), 0);
    send_byte(addr_byte(addr_sel, 1'b0), ack);   chk(!ack, "R4 ignored until START", 64'(ack), 0);
    send_byte(8'h5A, ack);                       chk(!ack, "R4 data ignored", 64'(ack), 0);
    bus_stop();
    bus_start();
    send_byte({5'b10010, addr_sel, 1'b0}, ack);  chk(!ack, "R4 high bits mismatch", 64'(ack), 0);
    bus_stop();
    chk(regs_out == flat_exp(), "R4 regs unchanged", regs_out, flat_exp());

    // R9 partial byte cut by STOP
    bus_start();
    send_byte(addr_byte(addr_sel, 1'b0), ack);
    send_byte(8'h03, ack);
    exp_ptr = 3'd3;
    send_bits(8'hA5, 5);
    bus_stop();
    chk(regs_out == flat_exp(), "R9 STOP abort no write", regs_out, flat_exp());
    do_read(1'b0, 8'h00, 1);  // R9 pointer not advanced by the aborted byte

    // R9 / R2 partial byte cut by repeated START, then a full write
    bus_start();
    send_byte(addr_byte(addr_sel, 1'b0), ack);
    send_byte(8'h05, ack);
    send_bits(8'h3C, 3);
    bus_start();
    send_byte(addr_byte(addr_sel, 1'b0), ack); chk(ack, "R2 repeated START readdress", 64'(ack), 1);
    send_byte(8'h01, ack);
    send_byte(8'hC3, ack);
    exp_regs[1] = 8'hC3;
    bus_stop();
    chk(regs_out == flat_exp(), "R9 restart abort no write", regs_out, flat_exp());

    // random phase over all strap values
    for (int t = 0; t < 12; t++) begin
      addr_sel = 2'($urandom);
      do_write(8'($urandom), 1 + int'($urandom % 10));
      do_read(1'b1, 8'($urandom), 1 + int'($urandom % 9));
    end

    chk(r5_viol == 0, "R5 drive changed while SCL high", 64'(r5_viol), 0);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule